// File: doc/BRIEF.md
# Pipelined Signed Array Multiplier

This block multiplies two 8-bit two's complement operands and returns their full 16-bit signed product. It is built for streaming datapaths such as filter tap arithmetic, where a new operand pair arrives on every clock and throughput matters more than latency. Each stage of the pipeline does one small piece of work: a single carry-save row, or a short chunk of the final carry-propagate addition.

The partial products are summed in rows of full adders, with a register after every row. Each bit of the second operand enters through its own skew register chain, so that it reaches its row in the same cycle as the data it belongs to. The partial-product terms that pair one sign bit with one non-sign bit are inverted. Two constant ones, at bit 8 and bit 15, correct the sign. Product bits that settle early, either in the array or in the first chunks of the merge adder, are carried along in deskew registers. All 16 bits therefore leave together after a fixed 12 register stages. A valid tag travels with every operand pair.

Top module: `sgn_pipe_mul`

## Requirements
- R1: `out_prod` equals the 16-bit two's complement product of `in_a` and `in_b`, both read as signed 8-bit values, for every input combination.
- R2: The latency is exactly 12 clock edges. Operands sampled with `in_valid` high at rising edge n appear on `out_prod`, with `out_valid` high, right after rising edge n+11, and stay there until edge n+12. All 16 product bits change in that same cycle.
- R3: A new operand pair is accepted on every clock edge. Back-to-back pairs each produce their own correct product in consecutive cycles, in the order they were applied.
- R4: `out_valid` is high exactly 12 edges after each edge that sampled `in_valid` high, and is low otherwise. Operands applied with `in_valid` low never produce a valid product.
- R5: While `rst_n` is low, `out_valid` is 0 and `out_prod` is 0x0000.
- R6: 0xFF times 0x55 (−1 × 85) yields 0xFFAB.
- R7: The extreme operands give exact results: −128 × −128 yields 0x4000, −128 × 127 yields 0xC080, and 0 times any value yields 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the operand pair on `in_a`/`in_b` as a real request |
| in_a | input | 8 | Multiplicand, two's complement |
| in_b | input | 8 | Multiplier, two's complement; each bit has its own skew chain |
| out_valid | output | 1 | High when `out_prod` holds the product of a valid request |
| out_prod | output | 16 | Signed product, two's complement |

## Verification
The first vectors are a single known pair (−1 × 85) and the three extremes. They separate a wrong sign correction or a wrong correction constant, which would show up on −128 × −128 and −128 × 127, from a broken array. A long back-to-back run of random operand pairs comes next. Because each product is compared in the exact cycle it is due, this run tells a misaligned skew or deskew chain, which mixes bits of neighbouring pairs, apart from a plain arithmetic error. A final random stream with `in_valid` switched on and off, and garbage operands during the gaps, shows that the valid tag keeps step with the data and that invalid slots never surface as results.

// File: rtl/sgn_mul_pkg.sv
package sgn_mul_pkg;

  // One bit of a sign-corrected partial product: a_j * b_i, inverted when
  // exactly one of the two factors is a sign bit.
  function automatic logic pp_bit(input logic a_j, input logic b_i,
                                  input int j, input int i, input int w);
    logic t;
    t = a_j & b_i;
    if ((j == w - 1) != (i == w - 1)) t = ~t;
    return t;
  endfunction

  // Constant correction: ones at weight w and weight 2w-1.
  function automatic logic bias_bit(input int k, input int w);
    return (k == w) || (k == 2 * w - 1);
  endfunction

  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/spm_skew_chain.sv
module spm_skew_chain #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic st [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) st[k] <= 1'b0;
    end else begin
      for (int k = DEPTH - 1; k > 0; k--) st[k] <= st[k-1];
      st[0] <= d;
    end
  end

  assign q = st[DEPTH-1];
endmodule

// File: rtl/spm_csa_row.sv
module spm_csa_row
  import sgn_mul_pkg::*;
#(
  parameter int OPW = 8,
  parameter int ROW = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_i,
  input  logic [OPW-1:0]    a_i,
  input  logic              b_bit,
  input  logic [2*OPW-1:0]  s_i,
  input  logic [2*OPW-1:0]  c_i,
  output logic              v_o,
  output logic [OPW-1:0]    a_o,
  output logic [2*OPW-1:0]  s_o,
  output logic [2*OPW-1:0]  c_o
);
  localparam int PW = 2 * OPW;
  localparam int AW = (OPW > 1) ? $clog2(OPW) : 1;

  logic [PW-1:0] pp_vec, s_n, c_n;

  always_comb begin
    pp_vec = '0;
    for (int k = 0; k < PW; k++) begin
      if (k >= ROW && k < ROW + OPW)
        pp_vec[k] = pp_bit(a_i[AW'(k - ROW)], b_bit, k - ROW, ROW, OPW);
    end
  end

  always_comb begin
    c_n = '0;
    s_n = '0;
    for (int k = 0; k < PW; k++) begin
      s_n[k] = fa_sum(s_i[k], c_i[k], pp_vec[k]);
      if (k < PW - 1) c_n[k+1] = fa_carry(s_i[k], c_i[k], pp_vec[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      a_o <= '0;
      s_o <= '0;
      c_o <= '0;
    end else begin
      v_o <= v_i;
      a_o <= a_i;
      s_o <= s_n;
      c_o <= c_n;
    end
  end

  // Named view: carry positions that must be empty once this row is done.
  logic [ROW:0] settled_carry;
  assign settled_carry = c_o[ROW:0];

  // R1: positions up to ROW are final, so no carry may remain there.
  a_r1_settled_carry_zero: assert property (
    @(posedge clk) disable iff (!rst_n) settled_carry == '0);

  generate
    if (ROW > 0) begin : g_deskew_chk
      // R2: bits settled by earlier rows ride through unchanged (deskew lane).
      a_r2_settled_bits_held: assert property (
        @(posedge clk) disable iff (!rst_n)
        1'b1 |=> s_o[ROW-1:0] == $past(s_i[ROW-1:0]));
    end
  endgenerate
endmodule

// File: rtl/spm_merge_stage.sv
module spm_merge_stage
  import sgn_mul_pkg::*;
#(
  parameter int OPW = 8,
  parameter int MB  = 3,
  parameter int IDX = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           v_i,
  input  logic [OPW-1:0] lo_i,
  input  logic [OPW-1:0] sh_i,
  input  logic [OPW-1:0] ch_i,
  input  logic [OPW-1:0] r_i,
  input  logic           cy_i,
  output logic           v_o,
  output logic [OPW-1:0] lo_o,
  output logic [OPW-1:0] sh_o,
  output logic [OPW-1:0] ch_o,
  output logic [OPW-1:0] r_o,
  output logic           cy_o
);
  localparam int LO = IDX * MB;
  localparam int HI = (LO + MB < OPW) ? LO + MB : OPW;

  logic [OPW-1:0] r_n;
  logic           cy_n;

  always_comb begin
    r_n  = r_i;
    cy_n = cy_i;
    for (int k = 0; k < OPW; k++) begin
      if (k >= LO && k < HI) begin
        r_n[k] = fa_sum(sh_i[k], ch_i[k], cy_n);
        cy_n   = fa_carry(sh_i[k], ch_i[k], cy_n);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o  <= 1'b0;
      lo_o <= '0;
      sh_o <= '0;
      ch_o <= '0;
      r_o  <= '0;
      cy_o <= 1'b0;
    end else begin
      v_o  <= v_i;
      lo_o <= lo_i;
      sh_o <= sh_i;
      ch_o <= ch_i;
      r_o  <= r_n;
      cy_o <= cy_n;
    end
  end

  // R2: the low product half is held in deskew registers through the merge.
  a_r2_low_half_deskewed: assert property (
    @(posedge clk) disable iff (!rst_n) 1'b1 |=> lo_o == $past(lo_i));

  generate
    if (IDX > 0) begin : g_done_chk
      // R2: chunks merged in earlier stages are held, not recomputed.
      a_r2_merged_chunks_held: assert property (
        @(posedge clk) disable iff (!rst_n)
        1'b1 |=> r_o[LO-1:0] == $past(r_i[LO-1:0]));
    end
  endgenerate
endmodule

// File: rtl/sgn_pipe_mul.sv
module sgn_pipe_mul
  import sgn_mul_pkg::*;
#(
  parameter int OPW        = 8,
  parameter int MERGE_BITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [OPW-1:0]     in_a,
  input  logic [OPW-1:0]     in_b,
  output logic               out_valid,
  output logic [2*OPW-1:0]   out_prod
);
  localparam int PW      = 2 * OPW;
  localparam int MSTAGES = (OPW + MERGE_BITS - 1) / MERGE_BITS;
  localparam int LATENCY = 1 + OPW + MSTAGES;

  // Array pipeline: index r holds the state entering row r.
  logic           v_pl [OPW+1];
  logic [OPW-1:0] a_pl [OPW+1];
  logic [PW-1:0]  s_pl [OPW+1];
  logic [PW-1:0]  c_pl [OPW+1];
  logic           b_sk [OPW];

  // Input register for the multiplicand and the valid tag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_pl[0] <= 1'b0;
      a_pl[0] <= '0;
    end else begin
      v_pl[0] <= in_valid;
      a_pl[0] <= in_a;
    end
  end

  assign s_pl[0] = '0;
  always_comb begin
    c_pl[0] = '0;
    for (int k = 0; k < PW; k++) c_pl[0][k] = bias_bit(k, OPW);
  end

  generate
    for (genvar r = 0; r < OPW; r++) begin : g_row
      spm_skew_chain #(.DEPTH(r + 1)) u_skew (
        .clk(clk), .rst_n(rst_n), .d(in_b[r]), .q(b_sk[r]));

      spm_csa_row #(.OPW(OPW), .ROW(r)) u_row (
        .clk(clk), .rst_n(rst_n),
        .v_i(v_pl[r]), .a_i(a_pl[r]), .b_bit(b_sk[r]),
        .s_i(s_pl[r]), .c_i(c_pl[r]),
        .v_o(v_pl[r+1]), .a_o(a_pl[r+1]),
        .s_o(s_pl[r+1]), .c_o(c_pl[r+1]));
    end
  endgenerate

  // Merge pipeline: carry-propagate the upper half in chunks.
  logic           v_m  [MSTAGES+1];
  logic [OPW-1:0] lo_m [MSTAGES+1];
  logic [OPW-1:0] sh_m [MSTAGES+1];
  logic [OPW-1:0] ch_m [MSTAGES+1];
  logic [OPW-1:0] r_m  [MSTAGES+1];
  logic           cy_m [MSTAGES+1];

  assign v_m[0]  = v_pl[OPW];
  assign lo_m[0] = s_pl[OPW][OPW-1:0];
  assign sh_m[0] = s_pl[OPW][PW-1:OPW];
  assign ch_m[0] = c_pl[OPW][PW-1:OPW];
  assign r_m[0]  = '0;
  assign cy_m[0] = 1'b0;

  generate
    for (genvar m = 0; m < MSTAGES; m++) begin : g_merge
      spm_merge_stage #(.OPW(OPW), .MB(MERGE_BITS), .IDX(m)) u_mrg (
        .clk(clk), .rst_n(rst_n),
        .v_i(v_m[m]), .lo_i(lo_m[m]), .sh_i(sh_m[m]), .ch_i(ch_m[m]),
        .r_i(r_m[m]), .cy_i(cy_m[m]),
        .v_o(v_m[m+1]), .lo_o(lo_m[m+1]), .sh_o(sh_m[m+1]), .ch_o(ch_m[m+1]),
        .r_o(r_m[m+1]), .cy_o(cy_m[m+1]));
    end
  endgenerate

  assign out_valid = v_m[MSTAGES];
  assign out_prod  = {r_m[MSTAGES], lo_m[MSTAGES]};

  // Named event: the array has finished and the low half must be carry-free.
  logic [OPW-1:0] array_low_carry;
  assign array_low_carry = c_pl[OPW][OPW-1:0];

  // R1: after the last row, no carry may remain in the settled low half.
  a_r1_array_low_carry_clear: assert property (
    @(posedge clk) disable iff (!rst_n) array_low_carry == '0);

  // R4: the valid tag is always a known value.
  a_r4_valid_known: assert property (
    @(posedge clk) disable iff (!rst_n) !$isunknown(out_valid));

  // R2: a valid product never carries unknown bits.
  a_r2_product_known: assert property (
    @(posedge clk) disable iff (!rst_n) out_valid |-> !$isunknown(out_prod));

  // R2: the pipeline depth is 12 for the default operand width.
  initial begin
    if (OPW == 8 && MERGE_BITS == 3)
      a_r2_depth_twelve: assert (LATENCY == 12);
  end
endmodule

// File: tb/test_sgn_pipe_mul.sv
module test_sgn_pipe_mul;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_a = '0;
  logic [7:0]  in_b = '0;
  logic        out_valid;
  logic [15:0] out_prod;

  sgn_pipe_mul i_sgn_pipe_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_prod(out_prod));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [15:0] prod;
    int          due;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return p[15:0];
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver: one operand pair per call, applied at the falling edge.
  task automatic drive(input logic v, input logic [7:0] a, input logic [7:0] b,
                       input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = v;
    in_a = a;
    in_b = b;
    if (v) begin
      e.prod = ref_mul(a, b);
      e.due  = cyc + LAT;
      e.tag  = tag;
      q.push_back(e);
    end
  endtask

  // Monitor: samples a quarter period after each rising edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          n_checks++;
          n_fail++;
          $display("FAIL R4: actual out_valid 1 expected 0 (no request due, cycle %0d)", cyc);
        end else begin
          exp_t e;
          e = q.pop_front();
          n_checks++;
          if (e.due != cyc) begin
            n_fail++;
            $display("FAIL R2: actual cycle %0d expected cycle %0d", cyc, e.due);
          end
          check(e.tag, out_prod, e.prod);
        end
      end else if (q.size() != 0 && q[0].due == cyc) begin
        n_checks++;
        n_fail++;
        $display("FAIL R4: actual out_valid 0 expected 1 (cycle %0d)", cyc);
        void'(q.pop_front());
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // R5: reset state, with activity on the inputs.
    in_valid = 1'b1;
    in_a = 8'h7F;
    in_b = 8'h81;
    repeat (4) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R5 out_valid", {15'd0, out_valid}, 16'h0000);
    check("R5 out_prod", out_prod, 16'h0000);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;

    // R6: the known pair.
    drive(1, 8'hFF, 8'h55, "R6 -1x85");
    // R7: extremes, back to back.
    drive(1, 8'h80, 8'h80, "R7 -128x-128");
    drive(1, 8'h80, 8'h7F, "R7 -128x127");
    drive(1, 8'h7F, 8'h80, "R7 127x-128");
    drive(1, 8'h00, 8'h80, "R7 0x-128");
    drive(1, 8'h00, 8'hFF, "R7 0x-1");
    drive(1, 8'h5A, 8'h00, "R7 x0");
    drive(1, 8'h7F, 8'h7F, "R1 127x127");
    drive(1, 8'hFF, 8'hFF, "R1 -1x-1");
    drive(1, 8'h01, 8'h80, "R1 1x-128");

    // R3: long back-to-back random stream.
    for (int k = 0; k < 300; k++)
      drive(1, 8'($urandom), 8'($urandom), "R3 back-to-back");

    // R4: gaps with garbage operands while in_valid is low.
    for (int k = 0; k < 200; k++) begin
      logic v;
      v = 1'($urandom);
      drive(v, 8'($urandom), 8'($urandom), "R4 gapped");
    end
    drive(0, 8'h80, 8'h80, "R4 idle");

    repeat (LAT + 4) @(posedge clk);
    #(CLK_PERIOD/4);
    // R4: every request came out, nothing is left pending.
    check("R4 pending", 16'(q.size()), 16'h0000);
    check("R4 idle out_valid", {15'd0, out_valid}, 16'h0000);
    finish_run();
  end
endmodule